// File: doc/BRIEF.md
# Ping-Pong Transfer Buffer with Per-Word DMA Handshake

This block carries 16-bit words in one direction, from a host processor bus to a DMA controller that serves a second processor. Its storage is two blocks of four words. At any moment the host owns one block and the DMA side owns the other. The host fills its block one word per write. When that block holds four words and the DMA-side block is empty, the two blocks trade owners on one clock edge. The DMA side then empties the full block one word at a time. Each word uses one request/acknowledge exchange.

Because ownership changes before the first request of a block, the host can refill the freshly emptied block while the DMA side is still draining. If the host completes a block while the DMA side still holds data, the full flag stays high until the DMA-side block is empty. While the flag is high, host writes are dropped. Both sides use one clock. A synchronous clear returns the block to its empty state.

Top module: `pingpong_xfer`

## Requirements
- R1: After reset or a synchronous clear, `host_full` and `dma_req` are low and both blocks are empty. A clear in the middle of a drain deasserts `dma_req`, and it stays low until a new block is completed.
- R2: After the host writes the fourth word of its block, `host_full` is high from the next edge. If the DMA-side block is empty, the owners swap on the following edge. From then on `host_full` is low and `dma_req` is high.
- R3: `dma_req` is a registered output. It is raised once for each of the four words of a block. After every accepted acknowledge it is low for exactly one cycle, and it is then raised again only if words remain.
- R4: During a cycle with `dma_req` and `dma_ack` both high, `dma_rd_data` shows the next word of the DMA-side block, in the order the host wrote it. While a request waits unacknowledged, `dma_rd_data` holds steady.
- R5: A host write made while `host_full` is high is dropped. It never appears on `dma_rd_data`.
- R6: While the DMA-side block still holds words, a completed host block keeps `host_full` high. The swap takes place on the edge after the edge that accepts the last acknowledge. This also covers the case where both events fall into the same cycle.
- R7: Once a swap has taken place, host writes to the new host block are accepted while the DMA side drains the other block.
- R8: A `dma_ack` in a cycle where `dma_req` is low is ignored. It neither advances the read position nor changes the data presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear; empties both blocks |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 16 | Host write word |
| host_full | output | 1 | Host block complete and waiting to swap; writes dropped |
| dma_req | output | 1 | Registered per-word transfer request |
| dma_ack | input | 1 | Acknowledge for the current request |
| dma_rd_data | output | 16 | Word presented to the DMA side |

## Verification
The hardest state to reach is a completed host block held back behind a DMA block that is still draining, in particular when the last acknowledge and the completion of the host block coincide. Directed sequences create this state on purpose. They fill a second block while the first is unacknowledged, attempt writes while full, and acknowledge with the request low. A seeded random phase then mixes write and acknowledge rates, so the host repeatedly runs into the held-full condition at varying phases. Every acknowledged word is compared against the bench's ordered record of accepted writes.

// File: rtl/ppx_pkg.sv
package ppx_pkg;
    parameter int unsigned WORD_W    = 16;
    parameter int unsigned BLK_WORDS = 4;
    localparam int unsigned NUM_BLK  = 2;

    typedef enum logic {
        BLK_A = 1'b0,
        BLK_B = 1'b1
    } blk_id_e;

    function automatic blk_id_e other_blk(input blk_id_e b);
        return (b == BLK_A) ? BLK_B : BLK_A;
    endfunction
endpackage

// File: rtl/ppx_wr_ctrl.sv
module ppx_wr_ctrl #(
    parameter int unsigned BLK_WORDS = ppx_pkg::BLK_WORDS,
    localparam int unsigned PTR_W    = $clog2(BLK_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             swap,
    output logic             accept,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             blk_full
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(BLK_WORDS - 1);

    assign accept = wr_en && !blk_full;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr   <= '0;
            blk_full <= 1'b0;
        end else if (swap) begin
            blk_full <= 1'b0;
        end else if (accept) begin
            if (wr_ptr == LAST) begin
                wr_ptr   <= '0;
                blk_full <= 1'b1;
            end else begin
                wr_ptr <= wr_ptr + 1'b1;
            end
        end
    end

    // R2: last word of the block sets the full flag
    a_r2_full_after_last: assert property (@(posedge clk) disable iff (rst || clr)
        accept && wr_ptr == LAST |=> blk_full);

    // R5: a held-full block neither moves its pointer nor clears by itself
    a_r5_hold_when_full: assert property (@(posedge clk) disable iff (rst || clr)
        blk_full && !swap |=> blk_full && wr_ptr == '0);
endmodule

// File: rtl/ppx_rd_ctrl.sv
module ppx_rd_ctrl #(
    parameter int unsigned BLK_WORDS = ppx_pkg::BLK_WORDS,
    localparam int unsigned PTR_W    = $clog2(BLK_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             swap,
    input  logic             ack,
    output logic             req,
    output logic             blk_full,
    output logic [PTR_W-1:0] rd_ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(BLK_WORDS - 1);

    logic take;
    assign take = ack && req;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            req      <= 1'b0;
            blk_full <= 1'b0;
            rd_ptr   <= '0;
        end else if (swap) begin
            req      <= 1'b1;
            blk_full <= 1'b1;
            rd_ptr   <= '0;
        end else if (take) begin
            req <= 1'b0;
            if (rd_ptr == LAST) begin
                rd_ptr   <= '0;
                blk_full <= 1'b0;
            end else begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end else if (blk_full && !req) begin
            req <= 1'b1;
        end
    end

    // R3: every accepted acknowledge drops the request for a cycle
    a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (rst || clr)
        take |=> !req);

    // R3: a request is only raised over a block that holds data
    a_r3_req_has_data: assert property (@(posedge clk) disable iff (rst || clr)
        req |-> blk_full);

    // R6: the last acknowledge frees the DMA-side block
    a_r6_free_after_last: assert property (@(posedge clk) disable iff (rst || clr)
        take && rd_ptr == LAST |=> !blk_full && !req);

    // R8: without a request the read position does not move
    a_r8_no_req_no_move: assert property (@(posedge clk) disable iff (rst || clr)
        !req && !swap |=> $stable(rd_ptr));
endmodule

// File: rtl/ppx_store.sv
module ppx_store #(
    parameter int unsigned WORD_W    = ppx_pkg::WORD_W,
    parameter int unsigned BLK_WORDS = ppx_pkg::BLK_WORDS,
    localparam int unsigned PTR_W    = $clog2(BLK_WORDS),
    localparam int unsigned CELLS    = ppx_pkg::NUM_BLK * BLK_WORDS
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wr_blk,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_blk,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [WORD_W-1:0] rd_data
);
    logic [CELLS*WORD_W-1:0] cells_flat;

    for (genvar b = 0; b < int'(ppx_pkg::NUM_BLK); b++) begin : g_blk
        for (genvar w = 0; w < int'(BLK_WORDS); w++) begin : g_word
            logic [WORD_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (we && wr_blk == 1'(b) && wr_ptr == PTR_W'(w))
                    cell_q <= wr_data;
            end
            assign cells_flat[(b*BLK_WORDS + w)*WORD_W +: WORD_W] = cell_q;
        end
    end

    int unsigned rd_idx;
    always_comb begin
        rd_idx  = 32'(rd_blk) * BLK_WORDS + 32'(rd_ptr);
        rd_data = cells_flat[rd_idx*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/pingpong_xfer.sv
module pingpong_xfer #(
    parameter int unsigned WORD_W    = ppx_pkg::WORD_W,
    parameter int unsigned BLK_WORDS = ppx_pkg::BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_data,
    output logic              host_full,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [WORD_W-1:0] dma_rd_data
);
    import ppx_pkg::*;
    localparam int unsigned PTR_W = $clog2(BLK_WORDS);

    blk_id_e          host_sel;
    logic             swap;
    logic             wr_accept;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             wr_blk_full;
    logic             rd_blk_full;

    assign swap      = wr_blk_full && !rd_blk_full;
    assign host_full = wr_blk_full;

    always_ff @(posedge clk) begin
        if (rst || clr)
            host_sel <= BLK_A;
        else if (swap)
            host_sel <= other_blk(host_sel);
    end

    ppx_wr_ctrl #(.BLK_WORDS(BLK_WORDS)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wr_en    (host_wr_en),
        .swap     (swap),
        .accept   (wr_accept),
        .wr_ptr   (wr_ptr),
        .blk_full (wr_blk_full)
    );

    ppx_rd_ctrl #(.BLK_WORDS(BLK_WORDS)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .swap     (swap),
        .ack      (dma_ack),
        .req      (dma_req),
        .blk_full (rd_blk_full),
        .rd_ptr   (rd_ptr)
    );

    ppx_store #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_store (
        .clk     (clk),
        .we      (wr_accept),
        .wr_blk  (host_sel),
        .wr_ptr  (wr_ptr),
        .wr_data (host_wr_data),
        .rd_blk  (other_blk(host_sel)),
        .rd_ptr  (rd_ptr),
        .rd_data (dma_rd_data)
    );

    // R2: an ownership change leaves the host free and a request pending
    a_r2_swap_raises_req: assert property (@(posedge clk) disable iff (rst || clr)
        !$stable(host_sel) |-> dma_req && !host_full);

    // R4: a waiting request keeps its data word steady
    a_r4_data_held: assert property (@(posedge clk) disable iff (rst || clr)
        dma_req && !dma_ack |=> $stable(dma_rd_data));

    // R1: after a clear nothing is requested or held full
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> !dma_req && !host_full);
endmodule

// File: tb/pingpong_xfer_tb.sv
module pingpong_xfer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        host_full;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic [15:0] dma_rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [15:0] expq[$];
    int wr_total = 0;

    always #4 clk = ~clk;

    pingpong_xfer u_dut (
        .clk(clk), .rst(rst), .clr(clr),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_full(host_full), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_rd_data(dma_rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit write_taken(input bit we, input logic full_s);
        return we && !full_s;
    endfunction

    function automatic bit ack_taken(input bit ack, input logic req_s);
        return ack && req_s;
    endfunction

    // Drive one cycle from a negedge; sample outputs before the edge.
    task automatic cyc(input bit we, input logic [15:0] wd, input bit ack, input string req);
        bit wt = write_taken(we, host_full);
        bit at = ack_taken(ack, dma_req);
        if (at) begin
            if (expq.size() == 0)
                chk(0, req, dma_rd_data, 16'hxxxx);
            else
                chk(dma_rd_data == expq[0], req, dma_rd_data, expq[0]);
            if (expq.size() != 0) void'(expq.pop_front());
        end
        if (wt) begin
            expq.push_back(wd);
            wr_total++;
        end
        host_wr_en   = we;
        host_wr_data = wd;
        dma_ack      = ack;
        @(negedge clk);
        host_wr_en = 1'b0;
        dma_ack    = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        expq.delete();
        wr_total = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!host_full, "R1 full after reset", host_full, 0);
        chk(!dma_req, "R1 req after reset", dma_req, 0);

        // R2 first block, DMA side empty
        for (int i = 0; i < 4; i++) cyc(1, 16'hA000 + 16'(i), 0, "R2");
        chk(host_full, "R2 full after 4th word", host_full, 1);
        chk(!dma_req, "R2 no req before swap", dma_req, 0);
        cyc(0, 0, 0, "R2");
        chk(!host_full, "R2 full clears on swap", host_full, 0);
        chk(dma_req, "R2 req after swap", dma_req, 1);

        // R7 refill while DMA block unacknowledged
        for (int i = 0; i < 4; i++) begin
            chk(!host_full, "R7 write accepted during drain", host_full, 0);
            cyc(1, 16'hB000 + 16'(i), 0, "R7");
        end
        // R6 held full behind busy DMA block; R5 writes dropped
        for (int i = 0; i < 3; i++) begin
            chk(host_full, "R6 full held", host_full, 1);
            cyc(1, 16'hDEAD, 0, "R5");
        end

        // R4 first word, R3 request drop
        cyc(0, 0, 1, "R4 word A0");
        chk(!dma_req, "R3 req low after ack", dma_req, 0);
        // R8 ack with req low ignored
        cyc(0, 0, 1, "R8");
        chk(dma_req, "R3 req re-raised", dma_req, 1);
        chk(dma_rd_data == 16'hA001, "R8 position unchanged", dma_rd_data, 16'hA001);
        cyc(0, 0, 0, "R4");
        chk(dma_rd_data == 16'hA001, "R4 data held while waiting", dma_rd_data, 16'hA001);
        for (int i = 1; i < 4; i++) begin
            cyc(0, 0, 1, "R4 word A");
            chk(!dma_req, "R3 req drop", dma_req, 0);
            if (i < 3) cyc(0, 0, 0, "R3");
        end
        // R6 swap on the edge after the last ack
        chk(host_full, "R6 full until swap edge", host_full, 1);
        cyc(0, 0, 0, "R6");
        chk(!host_full, "R6 swap after drain", host_full, 0);
        chk(dma_req, "R6 req after late swap", dma_req, 1);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 1, "R5 B block without dropped word");
            cyc(0, 0, 0, "R3");
        end
        chk(!dma_req, "R3 exactly four requests", dma_req, 0);
        chk(expq.size() == 0, "R5 no extra words", expq.size(), 0);

        // R6 coincident: host completes while last word is acknowledged
        for (int i = 0; i < 4; i++) cyc(1, 16'hC000 + 16'(i), 0, "R6");
        cyc(0, 0, 0, "R6");
        for (int i = 0; i < 3; i++) cyc(1, 16'hD000 + 16'(i), 0, "R6");
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 1, "R6 word C");
            cyc(0, 0, 0, "R6");
        end
        cyc(1, 16'hD003, 1, "R6 last word C");
        chk(host_full, "R6 coincident full", host_full, 1);
        chk(!dma_req, "R6 coincident no req", dma_req, 0);
        cyc(0, 0, 0, "R6");
        chk(!host_full && dma_req, "R6 coincident swap next edge", host_full, 0);

        // R1 clear mid-drain
        cyc(0, 0, 1, "R6 word D");
        do_clear();
        chk(!dma_req, "R1 req low after clear", dma_req, 0);
        chk(!host_full, "R1 full low after clear", host_full, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, "R1");
        chk(!dma_req, "R1 blocks empty after clear", dma_req, 0);
        for (int i = 0; i < 4; i++) cyc(1, 16'hE000 + 16'(i), 0, "R1");
        cyc(0, 0, 0, "R1");
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 1, "R1 fresh data after clear");
            cyc(0, 0, 0, "R1");
        end

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit we = ($urandom % 4) != 0;
            bit ak = ($urandom % 3) == 0;
            cyc(we, 16'($urandom), ak, "R4 random order");
        end
        for (int n = 0; n < 200; n++) cyc(0, 0, 1, "R4 drain");
        chk(!dma_req, "R3 drained req low", dma_req, 0);
        chk(expq.size() == wr_total % 4, "R7 partial block remains", expq.size(), wr_total % 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule